// File: doc/BRIEF.md
# Shared Bus Arbiter with Bus Lock and Master Latency Timer

This block decides which of several agents owns a shared parallel bus. Each agent raises a request line. While the bus is idle the arbiter grants it to one requester in rotating order. The granted agent then signals the start of its transaction and later its completion. One agent, the upstream agent, is special. It can open an exclusive locked sequence by completing a locked read without an abort. From then on, and until it sends an unlock, nobody else is granted.

A master latency timer bounds how long an owner keeps the bus while others wait. Software writes a reload value into a timer register. The counter is loaded with that value when a transaction starts and counts down once per clock while the bus is busy, stopping at zero. Once it reaches zero, a release indication tells the current owner to drop its frame at the next legal edge. This happens only if some other agent could actually be granted. During a lock no other agent can be granted, so the upstream owner is never told to let go.

Top module: `bus_arb_top`

## Requirements
- R1: After reset no grant is asserted, the bus is not busy, lock is not held, the count output is zero and the timer reload register holds the parameter RST_LAT.
- R2: At most one grant bit is high in any cycle, and the grant does not change while the bus is busy.
- R3: While the bus is idle, the grant register is updated every cycle to the first requesting eligible agent found by scanning upward (wrapping) from the index after the last agent that started a transaction. The scan begins at index 0 after reset. With no eligible request, no grant is given.
- R4: start_i with a grant present and the bus idle sets busy at the next edge. done_i while busy clears it. start_i with no grant or while busy has no effect.
- R5: Lock is taken at the edge after done_i for a locked read started by agent UP_IDX, but only if abort_i is low in that done_i cycle. If abort_i is high, lock stays free.
- R6: While lock is held, the only grant that may be given is to agent UP_IDX, even if other agents are requesting.
- R7: unlock_i clears a held lock at the next edge and round-robin arbitration among all requesters resumes. lock_rd_i on a transaction started by any agent other than UP_IDX has no effect on the lock.
- R8: On an accepted start the count loads the reload register value. While busy it then falls by one per clock and holds at zero.
- R9: frame_rel_o is high exactly when the bus is busy, the count is zero, and an eligible agent other than the owner is requesting. Under lock only UP_IDX is eligible.
- R10: A write to the reload register affects only transactions started after the edge that performs the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | N_AGENTS | Request line per agent |
| start_i | input | 1 | Granted agent begins a transaction |
| done_i | input | 1 | Current transaction ends |
| lock_rd_i | input | 1 | Qualifies start_i: transaction is a locked read |
| abort_i | input | 1 | Qualifies done_i: transaction ended in master or target abort |
| unlock_i | input | 1 | Upstream agent releases a held lock |
| tmr_wr_i | input | 1 | Write strobe for the timer reload register |
| tmr_wdata_i | input | TMR_W | Reload value to write |
| grant_o | output | N_AGENTS | One-hot-or-zero grant |
| busy_o | output | 1 | A transaction is in progress |
| locked_o | output | 1 | Bus lock is held |
| frame_rel_o | output | 1 | Owner must drop its frame at the next legal edge |
| tmr_cnt_o | output | TMR_W | Current latency count |

## Verification
If the rotation pointer is wrong, the wrong agent is granted on the first idle cycle where more than one agent requests. That shows up one edge after the bus goes idle. A lock state that is wrong shows on locked_o at the edge after done_i. It also shows as a non-upstream grant one idle cycle later. A counter or reload fault shows on tmr_cnt_o at the edge after the start. It also shifts frame_rel_o by the size of the error, and that is visible in the same cycle as the request pattern that qualifies it.

// File: rtl/bus_arb_pkg.sv
package bus_arb_pkg;

  typedef enum logic [1:0] {
    LK_FREE = 2'd0,
    LK_PEND = 2'd1,
    LK_HELD = 2'd2
  } lock_st_e;

  // saturating decrement on a 32-bit container; callers truncate
  function automatic int unsigned sat_dec(input int unsigned v);
    return (v == 0) ? 0 : v - 1;
  endfunction

  // next index on a ring of n slots
  function automatic int unsigned ring_idx(input int unsigned base,
                                           input int unsigned off,
                                           input int unsigned n);
    return (base + off) % n;
  endfunction

endpackage

// File: rtl/bus_arb_rr.sv
module bus_arb_rr #(
  parameter int N_AGENTS = 4,
  localparam int IW = (N_AGENTS > 1) ? $clog2(N_AGENTS) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [N_AGENTS-1:0] elig_i,
  input  logic                adv_i,
  input  logic [IW-1:0]       owner_i,
  output logic [N_AGENTS-1:0] pick_oh_o,
  output logic                pick_vld_o
);
  import bus_arb_pkg::*;

  logic [IW-1:0] last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     last_q <= IW'(N_AGENTS - 1);
    else if (adv_i) last_q <= owner_i;
  end

  always_comb begin
    int unsigned c;
    logic found;
    pick_oh_o = '0;
    found     = 1'b0;
    c         = 0;
    for (int off = 1; off <= N_AGENTS; off++) begin
      c = ring_idx(int'(last_q), off, N_AGENTS);
      if (!found && elig_i[c]) begin
        pick_oh_o[c] = 1'b1;
        found        = 1'b1;
      end
    end
    pick_vld_o = found;
  end

endmodule

// File: rtl/bus_arb_lock.sv
module bus_arb_lock (
  input  logic clk,
  input  logic rst_n,
  input  logic accept_i,
  input  logic owner_up_i,
  input  logic lock_rd_i,
  input  logic done_ok_i,
  input  logic abort_i,
  input  logic unlock_i,
  output logic locked_o,
  output logic pend_o
);
  import bus_arb_pkg::*;

  lock_st_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      LK_FREE: if (accept_i && owner_up_i && lock_rd_i) st_d = LK_PEND;
      LK_PEND: if (done_ok_i) st_d = abort_i ? LK_FREE : LK_HELD;
      LK_HELD: if (unlock_i) st_d = LK_FREE;
      default: st_d = LK_FREE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= LK_FREE;
    else        st_q <= st_d;
  end

  assign locked_o = (st_q == LK_HELD);
  assign pend_o   = (st_q == LK_PEND);

endmodule

// File: rtl/bus_arb_mlt.sv
module bus_arb_mlt #(
  parameter int TMR_W   = 8,
  parameter int RST_LAT = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_i,
  input  logic [TMR_W-1:0] wdata_i,
  input  logic             load_i,
  input  logic             run_i,
  output logic [TMR_W-1:0] cnt_o,
  output logic             zero_o
);
  import bus_arb_pkg::*;

  logic [TMR_W-1:0] reload_q;
  logic [TMR_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    reload_q <= TMR_W'(RST_LAT);
    else if (wr_i) reload_q <= wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (load_i) cnt_q <= reload_q;
    else if (run_i)  cnt_q <= TMR_W'(sat_dec(int'(cnt_q)));
  end

  assign cnt_o  = cnt_q;
  assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/bus_arb_top.sv
module bus_arb_top #(
  parameter int N_AGENTS = 4,
  parameter int UP_IDX   = 0,
  parameter int TMR_W    = 8,
  parameter int RST_LAT  = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [N_AGENTS-1:0] req_i,
  input  logic                start_i,
  input  logic                done_i,
  input  logic                lock_rd_i,
  input  logic                abort_i,
  input  logic                unlock_i,
  input  logic                tmr_wr_i,
  input  logic [TMR_W-1:0]    tmr_wdata_i,
  output logic [N_AGENTS-1:0] grant_o,
  output logic                busy_o,
  output logic                locked_o,
  output logic                frame_rel_o,
  output logic [TMR_W-1:0]    tmr_cnt_o
);
  localparam int IW = (N_AGENTS > 1) ? $clog2(N_AGENTS) : 1;
  localparam logic [N_AGENTS-1:0] UP_MASK = N_AGENTS'(1) << UP_IDX;

  function automatic logic [IW-1:0] oh_to_idx(input logic [N_AGENTS-1:0] oh);
    logic [IW-1:0] r;
    r = '0;
    for (int i = 0; i < N_AGENTS; i++) if (oh[i]) r = IW'(i);
    return r;
  endfunction

  logic [N_AGENTS-1:0] grant_q;
  logic                busy_q;
  logic                accept;
  logic                done_ok;
  logic                locked;
  logic                lock_pend;
  logic [N_AGENTS-1:0] elig;
  logic [N_AGENTS-1:0] pick_oh;
  logic                pick_vld;
  logic                cnt_zero;
  logic [IW-1:0]       owner_idx;
  logic                others_wait;

  assign accept    = start_i && !busy_q && (|grant_q);
  assign done_ok   = done_i && busy_q;
  assign owner_idx = oh_to_idx(grant_q);
  assign elig      = locked ? (req_i & UP_MASK) : req_i;
  assign others_wait = |(elig & ~grant_q);

  bus_arb_rr #(.N_AGENTS(N_AGENTS)) u_rr (
    .clk        (clk),
    .rst_n      (rst_n),
    .elig_i     (elig),
    .adv_i      (accept),
    .owner_i    (owner_idx),
    .pick_oh_o  (pick_oh),
    .pick_vld_o (pick_vld)
  );

  bus_arb_lock u_lock (
    .clk        (clk),
    .rst_n      (rst_n),
    .accept_i   (accept),
    .owner_up_i (grant_q[UP_IDX]),
    .lock_rd_i  (lock_rd_i),
    .done_ok_i  (done_ok),
    .abort_i    (abort_i),
    .unlock_i   (unlock_i),
    .locked_o   (locked),
    .pend_o     (lock_pend)
  );

  bus_arb_mlt #(.TMR_W(TMR_W), .RST_LAT(RST_LAT)) u_mlt (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_i    (tmr_wr_i),
    .wdata_i (tmr_wdata_i),
    .load_i  (accept),
    .run_i   (busy_q),
    .cnt_o   (tmr_cnt_o),
    .zero_o  (cnt_zero)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
    end else if (accept) begin
      busy_q <= 1'b1;
    end else if (done_ok) begin
      busy_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grant_q <= '0;
    end else if (!busy_q && !accept) begin
      grant_q <= pick_vld ? pick_oh : '0;
    end
  end

  assign grant_o     = grant_q;
  assign busy_o      = busy_q;
  assign locked_o    = locked;
  assign frame_rel_o = busy_q && cnt_zero && others_wait;

endmodule

// File: rtl/bus_arb_chk.sv
module bus_arb_chk #(
  parameter int N_AGENTS = 4,
  parameter int UP_IDX   = 0,
  parameter int TMR_W    = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic [N_AGENTS-1:0] grant_o,
  input logic                busy_o,
  input logic                done_i,
  input logic                abort_i,
  input logic                locked_o,
  input logic                frame_rel_o,
  input logic [TMR_W-1:0]    tmr_cnt_o
);
  localparam logic [N_AGENTS-1:0] UPM = N_AGENTS'(1) << UP_IDX;

  assert_grant_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_o));

  assert_grant_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && !done_i |=> $stable(grant_o));

  assert_lock_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    locked_o |-> ((grant_o & ~UPM) == '0));

  assert_lock_clean_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked_o) |-> $past(done_i && !abort_i && busy_o));

  assert_cnt_dec_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && (tmr_cnt_o != '0) |=> tmr_cnt_o == $past(tmr_cnt_o) - 1'b1);

  assert_release_cond_R9: assert property (@(posedge clk) disable iff (!rst_n)
    frame_rel_o |-> busy_o && (tmr_cnt_o == '0));

endmodule

bind bus_arb_top bus_arb_chk #(.N_AGENTS(N_AGENTS), .UP_IDX(UP_IDX), .TMR_W(TMR_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .grant_o     (grant_o),
  .busy_o      (busy_o),
  .done_i      (done_i),
  .abort_i     (abort_i),
  .locked_o    (locked_o),
  .frame_rel_o (frame_rel_o),
  .tmr_cnt_o   (tmr_cnt_o)
);

// File: tb/bus_arb_top_bench.sv
module bus_arb_top_bench;
  localparam int N  = 4;
  localparam int UP = 0;
  localparam int TW = 8;
  localparam int RL = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] req = '0;
  logic start = 0, done = 0, lock_rd = 0, abort = 0, unlock = 0, twr = 0;
  logic [TW-1:0] twd = '0;
  logic [N-1:0] grant;
  logic busy, locked, frel;
  logic [TW-1:0] cnt;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // reference model state
  int m_gnt = -1;
  int m_busy = 0;
  int m_cnt = 0;
  int m_reload = RL;
  int m_lock = 0;   // 0 free, 1 pending, 2 held
  int m_last = N - 1;

  always #4 clk = ~clk;

  bus_arb_top #(.N_AGENTS(N), .UP_IDX(UP), .TMR_W(TW), .RST_LAT(RL)) u_bus_arb_top (
    .clk(clk), .rst_n(rst_n), .req_i(req), .start_i(start), .done_i(done),
    .lock_rd_i(lock_rd), .abort_i(abort), .unlock_i(unlock),
    .tmr_wr_i(twr), .tmr_wdata_i(twd), .grant_o(grant), .busy_o(busy),
    .locked_o(locked), .frame_rel_o(frel), .tmr_cnt_o(cnt)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int elig_mask();
    int m;
    m = int'(req);
    if (m_lock == 2) m = m & (1 << UP);
    return m;
  endfunction

  function automatic int gvec();
    return (m_gnt < 0) ? 0 : (1 << m_gnt);
  endfunction

  function automatic int pick();
    int e;
    e = elig_mask();
    for (int k = 1; k <= N; k++) begin
      int c;
      c = (m_last + k) % N;
      if (e[c]) return c;
    end
    return -1;
  endfunction

  task automatic check_regs();
    chk("R2 grant", int'(grant), gvec());
    chk("R4 busy", int'(busy), m_busy);
    chk("R5 locked", int'(locked), (m_lock == 2) ? 1 : 0);
    chk("R8 count", int'(cnt), m_cnt);
  endtask

  // one cycle: inputs already driven at a negedge
  task automatic cyc();
    int acc, nxt_g, rel;
    #1;
    rel = (m_busy && m_cnt == 0 && ((elig_mask() & ~gvec()) != 0)) ? 1 : 0;
    chk("R9 frame release", int'(frel), rel);
    acc   = (start && !m_busy && m_gnt >= 0) ? 1 : 0;
    nxt_g = (!m_busy && !acc) ? pick() : m_gnt;
    @(posedge clk);
    if (m_lock == 2 && unlock) m_lock = 0;
    else if (m_lock == 0 && acc && lock_rd && m_gnt == UP) m_lock = 1;
    else if (m_lock == 1 && m_busy && done) m_lock = abort ? 0 : 2;
    if (acc) begin
      m_cnt  = m_reload;
      m_last = m_gnt;
    end else if (m_busy && m_cnt > 0) m_cnt = m_cnt - 1;
    if (acc) m_busy = 1;
    else if (m_busy && done) m_busy = 0;
    if (twr) m_reload = int'(twd);
    m_gnt = nxt_g;
    @(negedge clk);
    check_regs();
  endtask

  task automatic drive(input logic [N-1:0] r, input logic s, input logic d,
                       input logic lr, input logic ab, input logic ul);
    req = r; start = s; done = d; lock_rd = lr; abort = ab; unlock = ul;
    twr = 0;
    cyc();
  endtask

  task automatic idle(input logic [N-1:0] r, input int n);
    for (int i = 0; i < n; i++) drive(r, 0, 0, 0, 0, 0);
  endtask

  initial begin
    #2000000;
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 grant", int'(grant), 0);
    chk("R1 busy", int'(busy), 0);
    chk("R1 locked", int'(locked), 0);
    chk("R1 count", int'(cnt), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check_regs();

    // R3: scan starts at index 0; agents 1,2 requesting -> 1
    idle(4'b0110, 1);
    chk("R3 first pick", int'(grant), 4'b0010);
    // R1 reload default seen on first start
    drive(4'b0110, 1, 0, 0, 0, 0);
    chk("R1 reload default", int'(cnt), RL);
    idle(4'b0110, 3);
    drive(4'b0110, 0, 1, 0, 0, 0);
    idle(4'b0110, 1);
    chk("R3 rotation", int'(grant), 4'b0100);

    // R10: program 3, first start from here uses it
    req = 4'b0100; start = 0; done = 0; twr = 1; twd = 8'd3;
    cyc();
    drive(4'b0100, 1, 0, 0, 0, 0);
    chk("R10 new reload", int'(cnt), 3);
    idle(4'b0100, 5);  // expiry, nobody else waiting
    chk("R9 no release alone", int'(frel), 0);
    idle(4'b0101, 1);
    chk("R9 release with waiter", int'(frel), 1);
    drive(4'b0101, 0, 1, 0, 0, 0);
    idle(4'b0001, 1);
    // R4: start without grant ignored
    drive(4'b0000, 0, 0, 0, 0, 0);
    drive(4'b0000, 1, 0, 0, 0, 0);
    chk("R4 ignored start", int'(busy), 0);

    // R5: locked read with abort -> not locked
    idle(4'b0001, 1);
    drive(4'b0001, 1, 0, 1, 0, 0);
    idle(4'b0001, 2);
    drive(4'b0001, 0, 1, 0, 1, 0);
    chk("R5 abort no lock", int'(locked), 0);
    // clean locked read
    idle(4'b0001, 1);
    drive(4'b0001, 1, 0, 1, 0, 0);
    idle(4'b0001, 1);
    drive(4'b0001, 0, 1, 0, 0, 0);
    chk("R5 lock taken", int'(locked), 1);
    // R6: others requesting only
    idle(4'b1110, 3);
    chk("R6 no grant to others", int'(grant), 0);
    idle(4'b1111, 1);
    chk("R6 upstream granted", int'(grant), 4'b0001);
    drive(4'b1111, 1, 0, 0, 0, 0);
    idle(4'b1111, 6);
    chk("R9 no release under lock", int'(frel), 0);
    drive(4'b1111, 0, 1, 0, 0, 0);
    // R7: unlock
    drive(4'b1110, 0, 0, 0, 0, 1);
    chk("R7 unlock", int'(locked), 0);
    idle(4'b1110, 1);
    chk("R7 arbitration resumes", int'(grant) != 0 ? 1 : 0, 1);
    // R7: lock_rd from non-upstream ignored
    drive(4'b1110, 1, 0, 1, 0, 0);
    drive(4'b1110, 0, 1, 0, 0, 0);
    chk("R7 foreign lock ignored", int'(locked), 0);

    // mixed stimulus against the model (R2 R3 R4 R8 R9)
    for (int i = 0; i < 3000; i++) begin
      logic [N-1:0] r;
      r = N'($urandom);
      req = r;
      start   = ($urandom % 3) == 0;
      done    = ($urandom % 6) == 0;
      lock_rd = ($urandom % 4) == 0;
      abort   = ($urandom % 3) == 0;
      unlock  = ($urandom % 20) == 0;
      twr     = ($urandom % 40) == 0;
      twd     = TW'($urandom % 9);
      cyc();
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule